// File: doc/BRIEF.md
# Active Priority Bitmap Tracker

This block records which preemption levels are currently in service on a virtual interrupt CPU interface. It holds one bit per priority group. An acknowledge marks the group of the acknowledged interrupt as active. An end-of-interrupt retires the most urgent active group, which is the lowest-numbered set bit. The block reports that most urgent group as the running priority, written back in 8-bit priority form.

The number of implemented priority bits is a parameter with a value of 5, 6 or 7. This gives 32, 64 or 128 groups. Software sees the bitmap as up to four 32-bit words in a small register window. It reads them combinationally and overwrites them one whole word at a time. Words above the configured count read as zero and ignore writes.

Top module: `active_prio_tracker`

## Requirements
- R1: While and after synchronous active-high reset, every group bit is 0, run_valid is 0, run_prio is 8'hFF, and every word reads 0.
- R2: An acknowledge with priority p sets group bit g = p >> (8 - PRIO_BITS), so the upper PRIO_BITS bits of p select the group. Group g is bit g mod 32 of word g / 32. The bit is visible one cycle later.
- R3: An end-of-interrupt clears only the lowest-numbered set group bit. With no bit set it changes nothing.
- R4: run_prio is the lowest set group index shifted left by 8 - PRIO_BITS, and run_valid is 1 when any bit is set. With no bit set, run_prio is 8'hFF and run_valid is 0.
- R5: Word n decodes at byte address BASE_ADDR + 4*n, where BASE_ADDR defaults to 12'h0F0 and n runs from 0 to 3. reg_rdata follows reg_addr in the same cycle. Unaligned addresses and addresses outside the 16-byte window read 0 and ignore writes.
- R6: Words numbered 2^(PRIO_BITS-5) and above read 0 and ignore writes.
- R7: A write to an implemented word replaces all 32 bits, visible on the next cycle.
- R8: When acknowledge and end-of-interrupt arrive in the same cycle, the lowest set bit is cleared first and the acknowledged bit is set afterwards, so the new bit always survives.
- R9: A software write in the same cycle as an acknowledge or end-of-interrupt is applied first. The clear and then the set act on the written value.
- R10: Priorities that differ only in their low 8 - PRIO_BITS bits select the same group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_valid | input | 1 | An interrupt was acknowledged this cycle |
| ack_prio | input | 8 | Priority of the acknowledged interrupt |
| eoi_valid | input | 1 | End-of-interrupt this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address in the control window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| run_prio | output | 8 | Running priority, 8'hFF when idle |
| run_valid | output | 1 | At least one group is active |

## Verification
The bench drives one instance with 7 priority bits and one with 5 priority bits from the same stimulus. Each instance is compared against its own model.

The directed cases cover the following, with the failure each one exposes:
- An end-of-interrupt on an empty bitmap. A borrow that is not masked would set every bit.
- Acknowledge and end-of-interrupt in the same cycle, where the new group is the most urgent. Applying the operations in the wrong order wipes out the new bit.
- Writes to words 1 to 3 on the 5-bit instance. A decoder that ignores the configured word count would corrupt state that should not exist.
- Unaligned and out-of-window addresses, which a loose decoder would alias onto real words.
- Priorities that differ only in their dropped low bits, which a wrong shift would place in different groups.

Random traffic then mixes all of these.

// File: rtl/apt_pkg.sv
package apt_pkg;
   localparam int WORD_W    = 32;
   localparam int MAX_WORDS = 4;
   localparam int PRIO_W    = 8;

   function automatic int group_count(input int prio_bits);
      return 1 << prio_bits;
   endfunction

   function automatic int word_count(input int prio_bits);
      return group_count(prio_bits) / WORD_W;
   endfunction
endpackage

// File: rtl/apt_lsb_find.sv
module apt_lsb_find #(
   parameter int N  = 128,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          found
);
   if (N < 2) begin : g_bad_n
      $error("apt_lsb_find: N must be at least 2");
   end

   always_comb begin
      idx   = '0;
      found = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            idx   = IW'(i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/apt_addr_decode.sv
module apt_addr_decode #(
   parameter int                ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h0F0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [1:0]        word_sel
);
   if (ADDR_W < 5) begin : g_bad_w
      $error("apt_addr_decode: ADDR_W too small");
   end
   if (BASE_ADDR[3:0] != 4'h0) begin : g_bad_base
      $error("apt_addr_decode: BASE_ADDR must be 16-byte aligned");
   end

   assign hit      = (addr[ADDR_W-1:4] == BASE_ADDR[ADDR_W-1:4]) && (addr[1:0] == 2'b00);
   assign word_sel = addr[3:2];
endmodule

// File: rtl/active_prio_tracker.sv
module active_prio_tracker #(
   parameter int                PRIO_BITS = 7,
   parameter int                ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h0F0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ack_valid,
   input  logic [7:0]        ack_prio,
   input  logic              eoi_valid,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [7:0]        run_prio,
   output logic              run_valid
);
   import apt_pkg::*;

   localparam int GROUPS = group_count(PRIO_BITS);
   localparam int NWORDS = word_count(PRIO_BITS);
   localparam int SHIFT  = PRIO_W - PRIO_BITS;
   localparam int IDX_W  = PRIO_BITS;

   if (PRIO_BITS < 5 || PRIO_BITS > 7) begin : g_bad_prio
      $error("active_prio_tracker: PRIO_BITS must be 5, 6 or 7");
   end

   logic [GROUPS-1:0] bitmap;
   logic [GROUPS-1:0] b_wr, b_clr, b_next;
   logic              hit;
   logic [1:0]        word_sel;
   logic              word_impl;
   logic              wr_impl;
   logic [IDX_W-1:0]  ack_idx;
   logic [IDX_W-1:0]  low_idx;
   logic              low_found;
   logic [31:0]       words [MAX_WORDS];

   apt_addr_decode #(
      .ADDR_W   (ADDR_W),
      .BASE_ADDR(BASE_ADDR)
   ) u_dec (
      .addr    (reg_addr),
      .hit     (hit),
      .word_sel(word_sel)
   );

   assign word_impl = hit && ({30'd0, word_sel} < 32'(NWORDS));
   assign wr_impl   = reg_wr && word_impl;
   assign ack_idx   = IDX_W'(ack_prio >> SHIFT);

   // Order inside one cycle: software write, then clear, then set.
   always_comb begin
      b_wr = bitmap;
      if (wr_impl) b_wr[{word_sel, 5'd0} +: 32] = reg_wdata;
   end

   // b & (b-1) removes the lowest set bit; zero stays zero.
   assign b_clr  = eoi_valid ? (b_wr & (b_wr - GROUPS'(1))) : b_wr;
   assign b_next = ack_valid ? (b_clr | (GROUPS'(1) << ack_idx)) : b_clr;

   always_ff @(posedge clk) begin
      if (rst) bitmap <= '0;
      else     bitmap <= b_next;
   end

   apt_lsb_find #(.N(GROUPS), .IW(IDX_W)) u_low (
      .vec  (bitmap),
      .idx  (low_idx),
      .found(low_found)
   );

   assign run_valid = low_found;
   assign run_prio  = low_found ? {low_idx, {SHIFT{1'b0}}} : 8'hFF;

   for (genvar g = 0; g < MAX_WORDS; g++) begin : g_word
      if (g < NWORDS) begin : g_impl
         assign words[g] = bitmap[g*32 +: 32];
      end else begin : g_raz
         assign words[g] = 32'd0;
      end
   end

   assign reg_rdata = hit ? words[word_sel] : 32'd0;

   // ---------------- assertions ----------------
   p_ack_sets_r2: assert property (@(posedge clk) disable iff (rst)
      ack_valid && !eoi_valid && !wr_impl |=> bitmap[$past(ack_idx)]);

   p_eoi_clears_one_r3: assert property (@(posedge clk) disable iff (rst)
      eoi_valid && !ack_valid && !wr_impl |=>
         $countones(bitmap) == $past($countones(bitmap)) - ($past(run_valid) ? 1 : 0));

   p_idle_value_r4: assert property (@(posedge clk) disable iff (rst)
      !run_valid |-> run_prio == 8'hFF);

   p_raz_read_r6: assert property (@(posedge clk) disable iff (rst)
      hit && !word_impl |-> reg_rdata == 32'd0);

   p_wi_write_r6: assert property (@(posedge clk) disable iff (rst)
      reg_wr && !word_impl && !ack_valid && !eoi_valid |=> $stable(bitmap));

   p_set_survives_r8: assert property (@(posedge clk) disable iff (rst)
      ack_valid && eoi_valid && !wr_impl |=> bitmap[$past(ack_idx)]);
endmodule

// File: tb/active_prio_tracker_test.sv
`timescale 1ns/1ps
module active_prio_tracker_test;
   logic        clk = 1'b0;
   logic        rst;
   logic        ack_valid, eoi_valid, reg_wr;
   logic [7:0]  ack_prio;
   logic [11:0] reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] rd7, rd5;
   logic [7:0]  rp7, rp5;
   logic        rv7, rv5;

   logic [127:0] m7, m5;
   int errors = 0;
   int checks = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   active_prio_tracker #(.PRIO_BITS(7)) uut (
      .clk(clk), .rst(rst), .ack_valid(ack_valid), .ack_prio(ack_prio),
      .eoi_valid(eoi_valid), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rd7), .run_prio(rp7), .run_valid(rv7));

   active_prio_tracker #(.PRIO_BITS(5)) uut5 (
      .clk(clk), .rst(rst), .ack_valid(ack_valid), .ack_prio(ack_prio),
      .eoi_valid(eoi_valid), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rd5), .run_prio(rp5), .run_valid(rv5));

   function automatic logic [127:0] mdl_next(logic [127:0] bm, int p, logic wr,
         logic [11:0] a, logic [31:0] d, logic e, logic k, logic [7:0] pr);
      logic [127:0] b = bm;
      int n = 1 << (p - 5);
      int wi;
      if (wr && a[11:4] == 8'h0F && a[1:0] == 2'b00) begin
         wi = int'(a[3:2]);
         if (wi < n) b[32*wi +: 32] = d;
      end
      if (e) b = b & (b - 128'd1);
      if (k) b[int'(pr) >> (8 - p)] = 1'b1;
      return b;
   endfunction

   function automatic logic [31:0] mdl_rd(logic [127:0] bm, int p, logic [11:0] a);
      int n = 1 << (p - 5);
      int wi;
      if (a[11:4] != 8'h0F || a[1:0] != 2'b00) return 32'd0;
      wi = int'(a[3:2]);
      if (wi >= n) return 32'd0;
      return bm[32*wi +: 32];
   endfunction

   function automatic logic [8:0] mdl_run(logic [127:0] bm, int p);
      for (int i = 0; i < 128; i++)
         if (bm[i]) return {1'b1, 8'(i << (8 - p))};
      return {1'b0, 8'hFF};
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      logic [8:0] e7 = mdl_run(m7, 7);
      logic [8:0] e5 = mdl_run(m5, 5);
      chk(tag, "p7 rdata", rd7, mdl_rd(m7, 7, reg_addr));
      chk(tag, "p7 run_prio", {24'd0, rp7}, {24'd0, e7[7:0]});
      chk(tag, "p7 run_valid", {31'd0, rv7}, {31'd0, e7[8]});
      chk(tag, "p5 rdata", rd5, mdl_rd(m5, 5, reg_addr));
      chk(tag, "p5 run_prio", {24'd0, rp5}, {24'd0, e5[7:0]});
      chk(tag, "p5 run_valid", {31'd0, rv5}, {31'd0, e5[8]});
   endtask

   task automatic step(string tag, logic k, logic [7:0] pr, logic e,
                       logic wr, logic [11:0] a, logic [31:0] d);
      ack_valid = k; ack_prio = pr; eoi_valid = e;
      reg_wr = wr; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      m7 = mdl_next(m7, 7, wr, a, d, e, k, pr);
      m5 = mdl_next(m5, 5, wr, a, d, e, k, pr);
      @(negedge clk);
      ack_valid = 0; eoi_valid = 0; reg_wr = 0;
      #0.5;
      check_all(tag);
   endtask

   task automatic read_at(string tag, logic [11:0] a);
      reg_addr = a;
      #0.5;
      check_all(tag);
   endtask

   task automatic read_words(string tag);
      for (int w = 0; w < 4; w++) read_at(tag, 12'h0F0 + 12'(4 * w));
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int unsigned seed = 32'd17;
      void'($urandom(seed));
      rst = 1; ack_valid = 0; eoi_valid = 0; reg_wr = 0;
      ack_prio = 0; reg_addr = 12'h0F0; reg_wdata = 0;
      m7 = '0; m5 = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_all("R1");
      rst = 0;
      @(negedge clk);
      read_words("R1");

      // R2: group placement
      step("R2", 1, 8'h80, 0, 0, 12'h0F8, 0);
      read_words("R2");
      // R4: running priority with two active groups
      step("R4", 1, 8'h23, 0, 0, 12'h0F0, 0);
      // R3: retire lowest, then again, then on empty
      step("R3", 0, 0, 1, 0, 12'h0F0, 0);
      step("R3", 0, 0, 1, 0, 12'h0F8, 0);
      step("R3", 0, 0, 1, 0, 12'h0F0, 0);
      read_words("R3");
      // R7 / R6: whole-word writes, unimplemented words on 5-bit instance
      step("R7", 0, 0, 0, 1, 12'h0F4, 32'h8000_0001);
      step("R6", 0, 0, 0, 1, 12'h0FC, 32'hDEAD_BEEF);
      step("R7", 0, 0, 0, 1, 12'h0F0, 32'h0000_0100);
      read_words("R6");
      // R5: unaligned and out-of-window accesses
      step("R5", 0, 0, 0, 1, 12'h0F5, 32'hFFFF_FFFF);
      step("R5", 0, 0, 0, 1, 12'h1F0, 32'hFFFF_FFFF);
      read_at("R5", 12'h0F6);
      read_at("R5", 12'h1F0);
      read_at("R5", 12'h0E0);
      read_words("R5");
      // R8: ack of the most urgent group together with eoi
      step("R8", 1, 8'h02, 1, 0, 12'h0F0, 0);
      read_words("R8");
      step("R8", 1, 8'hFE, 1, 0, 12'h0FC, 0);
      // R9: write together with eoi and ack
      step("R9", 1, 8'h40, 1, 1, 12'h0F0, 32'h0000_0006);
      read_words("R9");
      // R10: low bits below the implemented width are dropped
      step("R10", 0, 0, 0, 1, 12'h0F0, 0);
      step("R10", 0, 0, 0, 1, 12'h0F4, 0);
      step("R10", 0, 0, 0, 1, 12'h0F8, 0);
      step("R10", 0, 0, 0, 1, 12'h0FC, 0);
      step("R10", 1, 8'h81, 0, 0, 12'h0F8, 0);
      step("R10", 1, 8'h87, 0, 0, 12'h0F8, 0);
      step("R10", 0, 0, 1, 0, 12'h0F0, 0);
      read_words("R10");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [3:0] r = 4'($urandom);
         logic [11:0] a;
         case (2'($urandom))
            2'd0, 2'd1: a = 12'h0F0 + 12'({$urandom} % 16);
            2'd2:       a = 12'h0F0 + 12'(4 * ($urandom % 4));
            default:    a = 12'($urandom);
         endcase
         step(i % 2 ? "R2" : "R3", r[0] | r[1], 8'($urandom), r[2],
              (r[3] && ($urandom % 4 == 0)), a, $urandom);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule